// File: doc/BRIEF.md
# Multiprocessor-Mode UART Transmitter

This block sends asynchronous serial frames that each carry one extra bit after the data byte. That extra bit tells listening stations whether the frame holds a station address (ID frame, bit = 1) or ordinary payload (data frame, bit = 0). The host drives a small register interface. It writes a byte into the holding register, chooses the frame kind with the multiprocessor-bit control, and then clears the data-empty flag to hand the byte over. A shift register takes the byte as soon as the line is free. Because the holding register and the shifter are separate, the host can queue the next byte while the current one is still on the wire, and frames go out back to back.

A frame is a low start bit, eight data bits least significant first, the multiprocessor bit, and a high stop bit. Each bit lasts 16 periods of the external baud tick. When transmit is first enabled, the line marks high for one whole frame time before any byte may leave. Clearing the enable aborts any frame in progress. The line then idles high, unless the break override is asserted, which holds it low.

The controller is a single state machine with these states:
- S_OFF: transmitter disabled.
- S_MARK: the idle frame of ones sent after enable.
- S_IDLE: waiting for a queued byte.
- S_START, S_DATA, S_MPB, S_STOP: the four frame phases.

Its transitions are:
- Any state goes to S_OFF when the enable is low.
- S_OFF goes to S_MARK when the enable is high.
- S_MARK goes to S_IDLE after eleven bit times.
- S_IDLE goes to S_START when a byte is pending.
- S_START goes to S_DATA after one bit time.
- S_DATA goes to S_MPB after the eighth data bit.
- S_MPB goes to S_STOP after one bit time.
- S_STOP goes to S_START if a byte is pending, otherwise to S_IDLE.

Top module: `mp_uart_tx`

## Requirements
- R1: After reset, txd is 1, tdre is 1 and tend is 1.
- R2: A frame is sent on txd as: one start bit of 0, then data bits 0 to 7 (least significant first), then the multiprocessor bit, then one stop bit of 1. Each bit lasts 16 baud ticks. txd changes only on a clock edge that follows a baud tick, except for the start bit of a byte taken from S_IDLE.
- R3: A byte whose multiprocessor-bit control (mpbt) was 1 at hand-off is sent as an ID frame, with the multiprocessor bit equal to 1.
- R4: A byte whose mpbt was 0 at hand-off is sent as a data frame, with the multiprocessor bit equal to 0.
- R5: After tx_en rises, txd stays 1 for 11 bit times before the first start bit. A byte queued during that time stays pending, so tdre stays 0.
- R6: tdre goes from 1 to 0 only through a tdre_clr pulse. When the shifter takes a pending byte, tdre returns to 1 and tend goes to 0 on the same edge, and the start bit begins.
- R7: If a byte is pending when a stop bit ends, its start bit follows at once, with no idle time between the frames.
- R8: tend returns to 1 when a stop bit ends and no byte is pending.
- R9: Dropping tx_en aborts any frame. txd is 1 while brk_ovr is 0, and tend is 1 from the next cycle.
- R10: With tx_en at 0, brk_ovr at 1 forces txd to 0. With tx_en at 1, brk_ovr has no effect on txd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit |
| tx_en | input | 1 | Transmit enable (control register bit) |
| brk_ovr | input | 1 | Port override that drives the line low while disabled |
| data_we | input | 1 | Write strobe for the transmit holding register |
| data_in | input | 8 | Byte written to the holding register |
| mpb_we | input | 1 | Write strobe for the multiprocessor-bit control |
| mpb_in | input | 1 | Value written to the multiprocessor-bit control |
| tdre_clr | input | 1 | Clears the data-empty flag, handing the byte over |
| txd | output | 1 | Serial output |
| tdre | output | 1 | Transmit-data-empty flag |
| tend | output | 1 | Transmit-end flag |
| mpbt | output | 1 | Readback of the multiprocessor-bit control |

## Verification
The bound checker watches the flag hand-off on every cycle. It checks four things:
- tdre falls only after a clear pulse.
- A fall of tend always coincides with the shifter taking a byte.
- Every take is followed by a low start bit.
- While enabled, txd moves only on tick boundaries, and tend stays high while disabled.

Only the bench's scenarios can show what a whole frame looks like: the bit order and the value of the multiprocessor bit for ID and data frames, the length of the marking frame after enable, the gapless back-to-back sequence, the abort, and the break level.

// File: rtl/mptx_pkg.sv
package mptx_pkg;
    typedef enum logic [2:0] {
        S_OFF,
        S_MARK,
        S_IDLE,
        S_START,
        S_DATA,
        S_MPB,
        S_STOP
    } tx_state_e;
endpackage

// File: rtl/mptx_hostregs.sv
module mptx_hostregs #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 data_we,
    input  logic [DATA_BITS-1:0] data_in,
    input  logic                 mpb_we,
    input  logic                 mpb_in,
    input  logic                 tdre_clr,
    input  logic                 load,
    output logic [DATA_BITS-1:0] hold_q,
    output logic                 mpbt_q,
    output logic                 tdre_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            mpbt_q <= 1'b0;
            tdre_q <= 1'b1;
        end else begin
            if (data_we) hold_q <= data_in;
            if (mpb_we)  mpbt_q <= mpb_in;
            // A byte taken by the shifter frees the holding register.
            if (load)
                tdre_q <= 1'b1;
            else if (tdre_clr && tdre_q)
                tdre_q <= 1'b0;
        end
    end
endmodule

// File: rtl/mptx_bittimer.sv
module mptx_bittimer #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic baud_tick,
    output logic bit_end
);
    localparam int CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

    logic [CW-1:0] cnt_q;

    assign bit_end = run && baud_tick && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (baud_tick)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/mp_uart_tx.sv
module mp_uart_tx
    import mptx_pkg::*;
#(
    parameter int DATA_BITS     = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 baud_tick,
    input  logic                 tx_en,
    input  logic                 brk_ovr,
    input  logic                 data_we,
    input  logic [DATA_BITS-1:0] data_in,
    input  logic                 mpb_we,
    input  logic                 mpb_in,
    input  logic                 tdre_clr,
    output logic                 txd,
    output logic                 tdre,
    output logic                 tend,
    output logic                 mpbt
);
    localparam int FRAME_BITS = DATA_BITS + 3;
    localparam int IDX_W      = $clog2(FRAME_BITS + 1);
    localparam logic [IDX_W-1:0] LAST_DATA  = IDX_W'(DATA_BITS - 1);
    localparam logic [IDX_W-1:0] LAST_FRAME = IDX_W'(FRAME_BITS - 1);

    tx_state_e state_q, state_d;
    logic [IDX_W-1:0]   bit_idx_q;
    logic [DATA_BITS:0] shreg_q;
    logic [DATA_BITS-1:0] hold_q;
    logic tend_q, line;
    logic run, bit_end, load;

    assign run  = tx_en && (state_q != S_OFF) && (state_q != S_IDLE);
    assign load = tx_en && !tdre &&
                  ((state_q == S_IDLE) || (state_q == S_STOP && bit_end));

    mptx_hostregs #(.DATA_BITS(DATA_BITS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_we  (data_we),
        .data_in  (data_in),
        .mpb_we   (mpb_we),
        .mpb_in   (mpb_in),
        .tdre_clr (tdre_clr),
        .load     (load),
        .hold_q   (hold_q),
        .mpbt_q   (mpbt),
        .tdre_q   (tdre)
    );

    mptx_bittimer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .baud_tick (baud_tick),
        .bit_end   (bit_end)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!tx_en) begin
            state_d = S_OFF;
        end else begin
            unique case (state_q)
                S_OFF:   state_d = S_MARK;
                S_MARK:  if (bit_end && bit_idx_q == LAST_FRAME) state_d = S_IDLE;
                S_IDLE:  if (load) state_d = S_START;
                S_START: if (bit_end) state_d = S_DATA;
                S_DATA:  if (bit_end && bit_idx_q == LAST_DATA) state_d = S_MPB;
                S_MPB:   if (bit_end) state_d = S_STOP;
                S_STOP:  if (bit_end) state_d = load ? S_START : S_IDLE;
                default: state_d = S_OFF;
            endcase
        end
    end

    // Datapath: bit index, shifter, end flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx_q <= '0;
            shreg_q   <= '0;
            tend_q    <= 1'b1;
        end else begin
            if (state_d != state_q)
                bit_idx_q <= '0;
            else if (bit_end)
                bit_idx_q <= bit_idx_q + 1'b1;

            if (load)
                shreg_q <= {mpbt, hold_q};
            else if (state_q == S_DATA && bit_end)
                shreg_q <= shreg_q >> 1;

            if (!tx_en)
                tend_q <= 1'b1;
            else if (load)
                tend_q <= 1'b0;
            else if (state_q == S_STOP && bit_end)
                tend_q <= 1'b1;
        end
    end

    // Output logic
    always_comb begin
        unique case (state_q)
            S_START:      line = 1'b0;
            S_DATA, S_MPB: line = shreg_q[0];
            default:      line = 1'b1;
        endcase
        if (tx_en) txd = line;
        else       txd = !brk_ovr;
    end

    assign tend = tend_q;
endmodule

// File: rtl/mp_uart_tx_checker.sv
module mp_uart_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic tx_en,
    input logic tdre_clr,
    input logic txd,
    input logic tdre,
    input logic tend
);
    // R6: the empty flag falls only after a host clear
    p_tdre_fall_by_host_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tdre) |-> $past(tdre_clr));

    // R6: the end flag drops only when the shifter takes a byte
    p_tend_fall_on_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tend) |-> $rose(tdre));

    // R2: a take starts a frame with a low start bit
    p_take_starts_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tdre) && tx_en) |-> !txd);

    // R2: while enabled the line moves only on tick boundaries or at a take
    p_line_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(txd) && tx_en && $past(tx_en)) |-> ($past(baud_tick) || $rose(tdre)));

    // R9: the end flag is high once the transmitter has been off a cycle
    p_tend_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !$past(tx_en)) |-> tend);
endmodule

bind mp_uart_tx mp_uart_tx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .tx_en     (tx_en),
    .tdre_clr  (tdre_clr),
    .txd       (txd),
    .tdre      (tdre),
    .tend      (tend)
);

// File: tb/mp_uart_tx_bench.sv
module mp_uart_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BITC       = 32;   // 16 ticks, one tick every 2 clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick = 1'b0;
    logic tx_en = 1'b0, brk_ovr = 1'b0;
    logic data_we = 1'b0, mpb_we = 1'b0, mpb_in = 1'b0, tdre_clr = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic txd, tdre, tend, mpbt;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    mp_uart_tx u_mp_uart_tx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
        .brk_ovr(brk_ovr), .data_we(data_we), .data_in(data_in),
        .mpb_we(mpb_we), .mpb_in(mpb_in), .tdre_clr(tdre_clr),
        .txd(txd), .tdre(tdre), .tend(tend), .mpbt(mpbt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            baud_tick = ~baud_tick;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic mp);
        int n = 0;
        while (!tdre && n < 2000) begin @(negedge clk); n++; end
        data_we = 1'b1; data_in = b; mpb_we = 1'b1; mpb_in = mp;
        @(negedge clk);
        data_we = 1'b0; mpb_we = 1'b0; tdre_clr = 1'b1;
        @(negedge clk);
        tdre_clr = 1'b0;
    endtask

    task automatic rx_frame(output logic [7:0] d, output logic mp,
                            output logic st, output bit found);
        int n = 0;
        found = 1'b0;
        d = '0; mp = 1'b0; st = 1'b0;
        while (txd && n < 3000) begin @(negedge clk); n++; end
        if (txd) return;
        found = 1'b1;
        repeat (BITC/2) @(negedge clk);
        if (txd) found = 1'b0;
        for (int i = 0; i < 8; i++) begin
            repeat (BITC) @(negedge clk);
            d[i] = txd;
        end
        repeat (BITC) @(negedge clk);
        mp = txd;
        repeat (BITC) @(negedge clk);
        st = txd;
    endtask

    task automatic enable_and_settle();
        tx_en = 1'b1;
        repeat (11*BITC + 10) @(negedge clk);
    endtask

    task automatic t_reset();
        check(txd == 1'b1, "R1", "txd after reset", txd, 1);
        check(tdre == 1'b1, "R1", "tdre after reset", tdre, 1);
        check(tend == 1'b1, "R1", "tend after reset", tend, 1);
    endtask

    task automatic t_enable_mark();
        logic [7:0] d; logic mp, st; bit f;
        int n = 0;
        bit all_high = 1'b1;
        tx_en = 1'b1;
        @(negedge clk); n++;
        send(8'h5A, 1'b0); n += 2;
        while (n < 11*BITC - 6) begin
            if (!txd) all_high = 1'b0;
            @(negedge clk); n++;
        end
        check(all_high, "R5", "line marks for one frame after enable", all_high, 1);
        check(tdre == 1'b0, "R5", "byte held during mark", tdre, 0);
        while (txd && n < 11*BITC + 20) begin @(negedge clk); n++; end
        check(n >= 11*BITC - 4 && n <= 11*BITC + 4, "R5", "start after mark (cycles)", n, 11*BITC);
        repeat (3) @(negedge clk);
        check(tdre == 1'b1, "R6", "tdre back to 1 after take", tdre, 1);
        check(tend == 1'b0, "R6", "tend low during frame", tend, 0);
        // line is mid start bit: finish decoding from here
        repeat (BITC/2 - 3) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (BITC) @(negedge clk);
            d[i] = txd;
        end
        repeat (BITC) @(negedge clk); mp = txd;
        repeat (BITC) @(negedge clk); st = txd;
        f = 1'b1;
        check(f && d == 8'h5A, "R2", "data bits LSB first", d, 8'h5A);
        check(mp == 1'b0, "R4", "data frame mp bit", mp, 0);
        check(st == 1'b1, "R2", "stop bit", st, 1);
        repeat (BITC) @(negedge clk);
        check(tend == 1'b1, "R8", "tend after last frame", tend, 1);
    endtask

    task automatic t_id_frame();
        logic [7:0] d; logic mp, st; bit f;
        send(8'hA5, 1'b1);
        check(mpbt == 1'b1, "R3", "control readback", mpbt, 1);
        rx_frame(d, mp, st, f);
        check(f && d == 8'hA5, "R3", "ID frame data", d, 8'hA5);
        check(mp == 1'b1, "R3", "ID frame mp bit", mp, 1);
        check(st == 1'b1, "R2", "ID frame stop", st, 1);
    endtask

    task automatic t_bit_width();
        int n = 0;
        send(8'h01, 1'b0);
        while (txd && n < 2000) begin @(negedge clk); n++; end
        n = 0;
        while (!txd && n < 200) begin @(negedge clk); n++; end
        check(n >= BITC - 1 && n <= BITC + 1, "R2", "start bit length (cycles)", n, BITC);
        while (!tend) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_back_to_back();
        logic [7:0] d1, d2; logic m1, m2, s1, s2; bit f1, f2;
        int n = 0;
        send(8'h81, 1'b1);
        while (!tdre || tend) begin @(negedge clk); n++; if (n > 2000) break; end
        send(8'h7E, 1'b0);
        rx_frame(d1, m1, s1, f1);
        repeat (BITC/2 + 4) @(negedge clk);
        check(txd == 1'b0, "R7", "second start follows stop", txd, 0);
        check(tend == 1'b0, "R7", "tend stays low between frames", tend, 0);
        repeat (BITC/2 - 4) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (BITC) @(negedge clk);
            d2[i] = txd;
        end
        repeat (BITC) @(negedge clk); m2 = txd;
        repeat (BITC) @(negedge clk); s2 = txd;
        f2 = 1'b1;
        check(f1 && d1 == 8'h81 && m1 == 1'b1 && s1, "R7", "first frame", {m1, d1}, 9'h181);
        check(f2 && d2 == 8'h7E && m2 == 1'b0 && s2, "R7", "second frame", {m2, d2}, 9'h07E);
        repeat (BITC) @(negedge clk);
        check(tend == 1'b1, "R8", "tend after queue drains", tend, 1);
    endtask

    task automatic t_abort();
        bit all_high = 1'b1;
        send(8'h00, 1'b0);
        repeat (3*BITC) @(negedge clk);
        check(txd == 1'b0, "R9", "frame running before abort", txd, 0);
        tx_en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 4*BITC; i++) begin
            if (!txd) all_high = 1'b0;
            @(negedge clk);
        end
        check(all_high, "R9", "line high after abort", all_high, 1);
        check(tend == 1'b1, "R9", "tend after abort", tend, 1);
    endtask

    task automatic t_break();
        bit all_high = 1'b1;
        enable_and_settle();
        brk_ovr = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!txd) all_high = 1'b0;
        end
        check(all_high, "R10", "override ignored while enabled", all_high, 1);
        tx_en = 1'b0;
        @(negedge clk);
        check(txd == 1'b0, "R10", "break holds line low", txd, 0);
        repeat (20) @(negedge clk);
        check(txd == 1'b0, "R10", "break still low", txd, 0);
        brk_ovr = 1'b0;
        @(negedge clk);
        check(txd == 1'b1, "R9", "idle high after break released", txd, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_enable_mark();
        t_id_frame();
        t_bit_width();
        t_back_to_back();
        t_abort();
        t_break();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule